// File: doc/BRIEF.md
# Interrupt-Driven Byte Serial Port Register Block

This block is the register face of a simple byte serial port on a 32-bit memory bus. Software sees four word registers. Two hold status for the receive and transmit directions, one returns the received byte, and one accepts a byte to transmit. The register window appears at two base addresses. A byte source outside the block presents bytes on a valid/data pair. The block pulls a byte from that source only while receive interrupts are enabled and no byte is already held. Reading the data register hands the held byte to software and frees the holding slot. Writing the transmit data register emits a one-cycle strobe that carries the low byte of the written word.

Each direction raises a level interrupt when its enable bit and its ready flag are both set. The transmitter is always ready, so its interrupt simply follows its enable bit. The two requests drive fixed lines of a processor interrupt vector: transmit on line 0 and receive on line 1.

The receive side is a two-state machine. In `RX_EMPTY` no byte is held. The transition `EMPTY->HELD (take)` fires when the enable is set and the source offers a byte. In `RX_HELD` a byte is held. The transition `HELD->EMPTY (consume)` fires on a data read when no new byte can be taken. The transition `HELD->HELD (refill)` fires on a data read while enabled, with a byte offered in the same cycle.

Top module: `serport_regs`

## Requirements
- R1: After reset both enable bits and the receive ready flag are 0, all interrupt lines are low, `tx_strobe` is low and `tx_byte` is 0.
- R2: A read of the transmit status register (offset 0x8) returns bit 0 (READY) as 1, bit 1 as the transmit enable, and all other bits as 0.
- R3: A write to the transmit data register (offset 0xC) makes `tx_strobe` high for exactly the next cycle, with `tx_byte` equal to bits 7:0 of the written word. `tx_byte` holds its value otherwise.
- R4: A write to the receive status register (offset 0x0) changes only the receive enable, taken from bit 1 of the written word. The ready flag and the held byte are left unchanged.
- R5: While the receive enable is 1 (counting an enable written in the same cycle) and no byte is held, `rx_avail` high makes `rx_take` high in that cycle. The byte is then latched and READY is 1 from the next cycle. While the enable is 0, `rx_take` stays low.
- R6: A read of the receive data register (offset 0x4) returns the held byte in bits 7:0 and clears READY when a byte is held. When no byte is held it returns 0.
- R7: A data read in the same cycle as `rx_avail`, with the enable at 1, takes the new byte, so READY stays 1 and the next read returns the new byte.
- R8: `irq_lines[1]` equals receive enable AND READY. It is registered, changing one cycle after the access or byte arrival that changes the condition.
- R9: `irq_lines[0]` equals the transmit enable (READY being always 1). It changes one cycle after the status write.
- R10: The 64-byte window decodes at base 0xFFFFC000 and at the mirror 0xFFFF0000. Any other address, and any in-window offset from 0x10 upward, reads 0 and ignores writes. The other interrupt lines stay 0.
- R11: A read of the receive status register returns bit 0 as READY and bit 1 as the receive enable, with other bits 0. A write to the transmit status register changes only the transmit enable, taken from bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the read, 0 when not reading |
| rx_avail | input | 1 | Source offers a byte |
| rx_byte | input | 8 | Offered byte |
| rx_take | output | 1 | Offered byte is taken this cycle |
| tx_strobe | output | 1 | Transmit byte valid (one cycle) |
| tx_byte | output | 8 | Transmit byte |
| irq_lines | output | 8 | Interrupt request levels, tx on 0, rx on 1 |

## Verification
The bench goes after the same-cycle collisions: a data read that meets an offered byte, and an enable write that meets an offered byte. A design that ignored the enable written in the same cycle would miss the byte and leave `rx_take` low. A design that cleared READY on every read would drop the refilled byte. It also writes a status register while a byte is held. A design that wrote the whole register there would wipe READY and lower the receive interrupt. Mirror, outside and unmapped offsets are mixed into a long random run. A decoder that compared too few address bits would then change state on writes that should be ignored, and the cycle-by-cycle model comparison would catch an interrupt that updated a cycle early or late.

// File: rtl/serport_pkg.sv
package serport_pkg;

    localparam int DATA_W    = 32;
    localparam int BYTE_W    = 8;
    localparam int BIT_READY = 0;
    localparam int BIT_IE    = 1;

    typedef enum logic [1:0] {
        REG_RX_STAT = 2'd0,
        REG_RX_DATA = 2'd1,
        REG_TX_STAT = 2'd2,
        REG_TX_DATA = 2'd3
    } reg_sel_e;

    typedef enum logic {
        RX_EMPTY = 1'b0,
        RX_HELD  = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic     hit;
        logic     wr;
        reg_sel_e sel;
    } bus_op_t;

endpackage

// File: rtl/serport_decode.sv
module serport_decode
    import serport_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          WIN_BITS  = 6,
    parameter logic [31:0] BASE      = 32'hFFFF_C000,
    parameter logic [31:0] MIRROR    = 32'hFFFF_0000,
    parameter bit          MIRROR_EN = 1'b1
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output bus_op_t           op
);
    localparam int TAG_W = ADDR_W - WIN_BITS;

    logic base_hit;
    logic mirror_hit;
    logic mapped;

    assign base_hit = (addr[ADDR_W-1:WIN_BITS] == BASE[ADDR_W-1:WIN_BITS]);

    generate
        if (MIRROR_EN) begin : g_mirror
            assign mirror_hit = (addr[ADDR_W-1:WIN_BITS] == MIRROR[ADDR_W-1:WIN_BITS]);
        end else begin : g_no_mirror
            assign mirror_hit = 1'b0;
        end
    endgenerate

    // only the first four words of the window carry registers
    assign mapped = (addr[WIN_BITS-1:4] == '0) && (TAG_W > 0);

    always_comb begin
        op.hit = sel && mapped && (base_hit || mirror_hit);
        op.wr  = wr;
        op.sel = reg_sel_e'(addr[3:2]);
    end
endmodule

// File: rtl/serport_rx.sv
module serport_rx
    import serport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bus_op_t           op,
    input  logic              wdata_ie,
    input  logic              rx_avail,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              rx_take,
    output logic [DATA_W-1:0] stat_word,
    output logic [DATA_W-1:0] data_word,
    output logic              irq
);
    rx_state_e         state_q, state_nxt;
    logic              ie_q, ie_nxt;
    logic [BYTE_W-1:0] byte_q;
    logic              irq_q;
    logic              wr_stat, rd_data;

    assign wr_stat = op.hit && op.wr && (op.sel == REG_RX_STAT);
    assign rd_data = op.hit && !op.wr && (op.sel == REG_RX_DATA);
    assign ie_nxt  = wr_stat ? wdata_ie : ie_q;

    // next-state and take logic
    always_comb begin
        state_nxt = state_q;
        rx_take   = 1'b0;
        unique case (state_q)
            RX_EMPTY: begin
                if (ie_nxt && rx_avail) begin
                    rx_take   = 1'b1;
                    state_nxt = RX_HELD;
                end
            end
            RX_HELD: begin
                if (rd_data) begin
                    if (ie_nxt && rx_avail) begin
                        rx_take = 1'b1;
                    end else begin
                        state_nxt = RX_EMPTY;
                    end
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_EMPTY;
            ie_q    <= 1'b0;
            byte_q  <= '0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_nxt;
            ie_q    <= ie_nxt;
            if (rx_take) byte_q <= rx_byte;
            irq_q   <= ie_nxt && (state_nxt == RX_HELD);
        end
    end

    // outputs
    always_comb begin
        stat_word            = '0;
        stat_word[BIT_READY] = (state_q == RX_HELD);
        stat_word[BIT_IE]    = ie_q;
        data_word            = '0;
        if (state_q == RX_HELD) data_word[BYTE_W-1:0] = byte_q;
    end
    assign irq = irq_q;

    a_r5_take_needs_avail: assert property (@(posedge clk) disable iff (!rst_n)
        rx_take |-> rx_avail);
    a_r5_take_fills: assert property (@(posedge clk) disable iff (!rst_n)
        rx_take |=> (state_q == RX_HELD) && (byte_q == $past(rx_byte)));
    a_r6_read_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_HELD && rd_data && !rx_avail) |=> (state_q == RX_EMPTY));
    a_r4_stat_write_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && state_q == RX_HELD) |=> (state_q == RX_HELD) && $stable(byte_q));
    a_r8_irq_matches_state: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (ie_q && state_q == RX_HELD));
endmodule

// File: rtl/serport_tx.sv
module serport_tx
    import serport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bus_op_t           op,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] stat_word,
    output logic              tx_strobe,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              irq
);
    logic              ie_q;
    logic              strobe_q;
    logic [BYTE_W-1:0] byte_q;
    logic              irq_q;
    logic              wr_stat, wr_data, ie_nxt;

    assign wr_stat = op.hit && op.wr && (op.sel == REG_TX_STAT);
    assign wr_data = op.hit && op.wr && (op.sel == REG_TX_DATA);
    assign ie_nxt  = wr_stat ? wdata[BIT_IE] : ie_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q     <= 1'b0;
            strobe_q <= 1'b0;
            byte_q   <= '0;
            irq_q    <= 1'b0;
        end else begin
            ie_q     <= ie_nxt;
            strobe_q <= wr_data;
            if (wr_data) byte_q <= wdata[BYTE_W-1:0];
            irq_q    <= ie_nxt;  // transmitter is always ready
        end
    end

    always_comb begin
        stat_word            = '0;
        stat_word[BIT_READY] = 1'b1;
        stat_word[BIT_IE]    = ie_q;
    end
    assign tx_strobe = strobe_q;
    assign tx_byte   = byte_q;
    assign irq       = irq_q;

    a_r3_write_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> tx_strobe && (tx_byte == $past(wdata[BYTE_W-1:0])));
    a_r3_strobe_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> $past(wr_data));
    a_r9_irq_follows_ie: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> (irq == $past(wdata[BIT_IE])));
endmodule

// File: rtl/serport_regs.sv
module serport_regs
    import serport_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          WIN_BITS  = 6,
    parameter logic [31:0] BASE      = 32'hFFFF_C000,
    parameter logic [31:0] MIRROR    = 32'hFFFF_0000,
    parameter bit          MIRROR_EN = 1'b1,
    parameter int          IRQ_N     = 8,
    parameter int          TX_LINE   = 0,
    parameter int          RX_LINE   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_avail,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              rx_take,
    output logic              tx_strobe,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [IRQ_N-1:0]  irq_lines
);
    bus_op_t           op;
    logic [DATA_W-1:0] rx_stat_w, rx_data_w, tx_stat_w;
    logic              rx_irq, tx_irq;

    serport_decode #(
        .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .BASE(BASE),
        .MIRROR(MIRROR), .MIRROR_EN(MIRROR_EN)
    ) i_decode (
        .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .op(op)
    );

    serport_rx i_rx (
        .clk(clk), .rst_n(rst_n), .op(op), .wdata_ie(bus_wdata[BIT_IE]),
        .rx_avail(rx_avail), .rx_byte(rx_byte), .rx_take(rx_take),
        .stat_word(rx_stat_w), .data_word(rx_data_w), .irq(rx_irq)
    );

    serport_tx i_tx (
        .clk(clk), .rst_n(rst_n), .op(op), .wdata(bus_wdata),
        .stat_word(tx_stat_w), .tx_strobe(tx_strobe), .tx_byte(tx_byte),
        .irq(tx_irq)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (op.hit && !op.wr) begin
            unique case (op.sel)
                REG_RX_STAT: bus_rdata = rx_stat_w;
                REG_RX_DATA: bus_rdata = rx_data_w;
                REG_TX_STAT: bus_rdata = tx_stat_w;
                REG_TX_DATA: bus_rdata = '0;
            endcase
        end
    end

    // interrupt line routing
    generate
        for (genvar g = 0; g < IRQ_N; g++) begin : g_irq
            if (g == TX_LINE) begin : g_tx
                assign irq_lines[g] = tx_irq;
            end else if (g == RX_LINE) begin : g_rx
                assign irq_lines[g] = rx_irq;
            end else begin : g_idle
                assign irq_lines[g] = 1'b0;
            end
        end
    endgenerate

    a_r2_tx_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (op.hit && !op.wr && op.sel == REG_TX_STAT) |-> bus_rdata[BIT_READY]);
    a_r10_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !op.hit |-> (bus_rdata == '0));
    a_r10_miss_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !op.hit |=> !tx_strobe);
endmodule

// File: tb/test_serport_regs.sv
module test_serport_regs;
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [31:0] BASE   = 32'hFFFF_C000;
    localparam logic [31:0] MIRROR = 32'hFFFF_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_avail = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_take, tx_strobe;
    logic [7:0]  tx_byte;
    logic [7:0]  irq_lines;

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural model state
    bit       m_rx_ie, m_ready, m_tx_ie, m_irq_rx, m_irq_tx, m_stb;
    bit [7:0] m_byte, m_txb;

    always #5 clk = ~clk;

    serport_regs i_serport_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_avail(rx_avail), .rx_byte(rx_byte), .rx_take(rx_take),
        .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq_lines(irq_lines)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(bit s, bit w, logic [31:0] a, logic [31:0] d, bit av, logic [7:0] b);
        bit       hit, rd_data, ie_n, rdy_after, take, txie_n, wr_tx;
        bit [3:0] off;
        logic [31:0] exp_rd;
        string    tag;
        @(negedge clk);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; rx_avail = av; rx_byte = b;
        #2;
        off = a[5:2];
        hit = s && (a[31:6] == BASE[31:6] || a[31:6] == MIRROR[31:6]) && off < 4;
        rd_data = hit && !w && off == 1;
        ie_n = (hit && w && off == 0) ? d[1] : m_rx_ie;
        rdy_after = m_ready && !rd_data;
        take = ie_n && !rdy_after && av;
        txie_n = (hit && w && off == 2) ? d[1] : m_tx_ie;
        wr_tx = hit && w && off == 3;
        exp_rd = 32'h0;
        tag = "R10";
        if (hit && !w) begin
            case (off)
                4'd0: begin exp_rd = {30'b0, m_rx_ie, m_ready}; tag = "R11"; end
                4'd1: begin exp_rd = m_ready ? {24'b0, m_byte} : 32'h0; tag = "R6"; end
                4'd2: begin exp_rd = {30'b0, m_tx_ie, 1'b1}; tag = "R2"; end
                default: exp_rd = 32'h0;
            endcase
        end
        chk(tag, "bus_rdata", bus_rdata, exp_rd);
        chk("R5", "rx_take", {31'b0, rx_take}, {31'b0, take});
        chk("R8", "irq_rx", {31'b0, irq_lines[1]}, {31'b0, m_irq_rx});
        chk("R9", "irq_tx", {31'b0, irq_lines[0]}, {31'b0, m_irq_tx});
        chk("R10", "irq_other", {26'b0, irq_lines[7:2]}, 32'h0);
        chk("R3", "tx_strobe", {31'b0, tx_strobe}, {31'b0, m_stb});
        chk("R3", "tx_byte", {24'b0, tx_byte}, {24'b0, m_txb});
        @(posedge clk);
        #1;
        if (rst_n) begin
            m_rx_ie = ie_n;
            if (take) m_byte = b;
            m_ready = rdy_after || take;
            m_tx_ie = txie_n;
            m_irq_rx = m_rx_ie && m_ready;
            m_irq_tx = m_tx_ie;
            m_stb = wr_tx;
            if (wr_tx) m_txb = d[7:0];
        end
    endtask

    task automatic idle();
        step(0, 0, 32'h0, 32'h0, 0, 8'h00);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        {m_rx_ie, m_ready, m_tx_ie, m_irq_rx, m_irq_tx, m_stb} = '0;
        m_byte = '0; m_txb = '0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state visible at the ports
        idle();
        step(1, 0, BASE + 0, 0, 0, 0);          // R11 status after reset
        step(1, 0, BASE + 8, 0, 0, 0);          // R2 tx ready
        // R6: empty data read returns 0
        step(1, 0, BASE + 4, 0, 1, 8'hA5);      // R5: IE off, no take
        // R5: enable write with byte offered in the same cycle
        step(1, 1, BASE + 0, 32'h2, 1, 8'h3C);
        idle();                                 // R8 irq rx high
        step(1, 0, BASE + 0, 0, 0, 0);
        // R4: status write while held keeps READY
        step(1, 1, BASE + 0, 32'hFFFF_FFFD, 1, 8'h77);
        idle();
        step(1, 1, BASE + 0, 32'h2, 0, 0);
        // R7: read with refill
        step(1, 0, BASE + 4, 0, 1, 8'h5A);
        idle();
        step(1, 0, BASE + 4, 0, 0, 0);          // R6 consume
        idle();
        step(1, 0, BASE + 4, 0, 0, 0);
        // R3 / R9: transmit side
        step(1, 1, BASE + 12, 32'h1234_56C3, 0, 0);
        idle();
        step(1, 1, BASE + 8, 32'h0000_0003, 0, 0);
        idle();
        step(1, 0, BASE + 8, 0, 0, 0);
        // R10: mirror, outside and unmapped offsets
        step(1, 1, MIRROR + 12, 32'h0000_0099, 0, 0);
        step(1, 1, 32'hFFFF_8000, 32'h0, 0, 0);
        step(1, 1, BASE + 16, 32'h0, 0, 0);
        step(1, 0, BASE + 20, 0, 0, 0);
        step(1, 1, MIRROR + 8, 32'h0, 0, 0);
        idle();
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a;
            int pick;
            pick = $urandom_range(0, 9);
            a = (pick < 5) ? BASE : (pick < 8) ? MIRROR : 32'h1000_0000;
            a = a + {$urandom_range(0, 5), 2'b00};
            step($urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0, a,
                 $urandom, $urandom_range(0, 1) == 1, 8'($urandom));
        end
        summary();
        $finish;
    end
endmodule